// File: doc/BRIEF.md
# Multicycle Accumulator Processor Controller

This block is a small accumulator machine that executes one instruction at a time through an explicit register-transfer sequence. A program counter, an address latch (MAR), a data latch (MDR), an instruction register and an accumulator are each updated in their own cycle. Memory is only reached through MAR for the address and MDR for the data. The core drives a single-port synchronous memory that has one cycle of read latency.

An instruction is 16 bits wide. The opcode sits in bits [15:12] and a 12-bit memory address sits in bits [11:0]. The opcodes are:

| Code | Instruction |
|---|---|
| 0 | halt |
| 1 | load |
| 2 | store |
| 3 | add |
| 4 | subtract |
| 5 | bitwise and |
| 6 | unconditional jump |
| 7 | jump-if-accumulator-zero |
| 8..15 | no-operation |

After reset the core fetches from address 0 and keeps running until it reaches a halt. Debug outputs expose the current sequencer state and every architectural register, so the system can follow each register transfer.

The sequencer state codes are:

| Code | State | Action |
|---|---|---|
| 0 | FA | PC to MAR |
| 1 | FR | read presented |
| 2 | FM | read data to MDR |
| 3 | FI | MDR to IR |
| 4 | FP | PC plus one |
| 5 | DEC | decode |
| 6 | XA | operand address to MAR |
| 7 | XR | operand read presented |
| 8 | XM | read data to MDR |
| 9 | XACC | accumulator update |
| 10 | SD | ACC to MDR |
| 11 | SW | write pulse |
| 12 | BR | branch |
| 13 | HLT | halted |

Top module: `acc_cpu_core`

## Requirements
- R1: Fetch runs in the fixed order FA→FR→FM→FI→FP→DEC:
  - In FA, MAR takes PC.
  - In FR, the read is presented on mem_addr.
  - In FM, MDR takes mem_rdata.
  - In FI, IR takes MDR.
- R2: PC is incremented by one in the FP state, before decode and execute. At the end of fetch, PC holds the address of the next sequential instruction.
- R3: During DEC there is no memory transfer. mem_we stays low and MAR and MDR keep their values.
- R4: A load (opcode 1) runs XA, XR, XM, XACC and leaves ACC equal to memory at the operand address.
- R5: Add (3), subtract (4, ACC minus memory) and and (5) fetch the operand through MAR and MDR in the same way. They write the ACC op operand result, taken modulo 2^16, back into ACC.
- R6: A store (opcode 2) puts the operand address in MAR, copies ACC into MDR and then asserts mem_we for exactly one cycle. In that cycle mem_addr is the operand address and mem_wdata is the ACC value.
- R7: A jump (6) loads the address field into PC and discards the incremented value. Jump-if-zero (7) does the same only when ACC is zero; otherwise the incremented PC is kept.
- R8: After execute the next fetch starts at once. Per instruction, from leaving FA to re-entering FA, the cycle counts are:
  - 6 for a no-operation.
  - 7 for a jump.
  - 9 for a store.
  - 10 for a load or ALU instruction.
- R9: A halt (0) enters HLT after 6 cycles of fetch and decode. In HLT, halted is 1, all registers are frozen and no write happens, until reset.
- R10: Opcodes 8 to 15 change only PC, which advances by one. ACC is unchanged and no write happens.
- R11: Reset clears PC, ACC, IR, MAR and MDR to zero, selects state FA and holds halted and mem_we low.
- R12: PC wraps modulo 4096, so the instruction at 4095 is followed by the one at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address, always the MAR value |
| mem_wdata | output | 16 | Write data, always the MDR value |
| mem_we | output | 1 | Write enable, one-cycle pulse |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High while in the halt state |
| dbg_state | output | 4 | Current sequencer state code |
| dbg_pc | output | 12 | Program counter |
| dbg_mar | output | 12 | Memory address register |
| dbg_mdr | output | 16 | Memory data register |
| dbg_ir | output | 16 | Instruction register |
| dbg_acc | output | 16 | Accumulator |

## Verification
A directed program traces the first fetch cycle by cycle, which separates a correct transfer order from one that swaps or merges steps. It then mixes taken and untaken zero-branches, an unconditional jump over a store, and a no-operation opcode, which tells overridden PC values apart from sequential ones. A wrap program fetches from address 4095 and shows whether PC rolls over to 0. Constrained-random programs of forward jumps and data-area accesses are compared with a bench interpreter on the final accumulator, PC, memory image, write count and total cycle count; the cycle count exposes any state that is skipped or repeated.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [3:0] {
      S_FA   = 4'd0,
      S_FR   = 4'd1,
      S_FM   = 4'd2,
      S_FI   = 4'd3,
      S_FP   = 4'd4,
      S_DEC  = 4'd5,
      S_XA   = 4'd6,
      S_XR   = 4'd7,
      S_XM   = 4'd8,
      S_XACC = 4'd9,
      S_SD   = 4'd10,
      S_SW   = 4'd11,
      S_BR   = 4'd12,
      S_HLT  = 4'd13
   } cpu_state_e;

   localparam int OPC_HALT  = 0;
   localparam int OPC_LOAD  = 1;
   localparam int OPC_STORE = 2;
   localparam int OPC_ADD   = 3;
   localparam int OPC_SUB   = 4;
   localparam int OPC_AND   = 5;
   localparam int OPC_JUMP  = 6;
   localparam int OPC_JZ    = 7;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int OP_W        = 4,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] result
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] diff;

   // subtractor variant chosen at elaboration
   generate
      if (SUB_VIA_ADD) begin : g_sub_add
         assign diff = acc_in + ~opnd + ONE;
      end else begin : g_sub_direct
         assign diff = acc_in - opnd;
      end
   endgenerate

   always_comb begin
      if (op == OP_W'(OPC_ADD))      result = acc_in + opnd;
      else if (op == OP_W'(OPC_SUB)) result = diff;
      else if (op == OP_W'(OPC_AND)) result = acc_in & opnd;
      else                           result = opnd;
   end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] op,
   output cpu_state_e      state
);

   cpu_state_e nxt;
   logic       is_mem_rd;

   assign is_mem_rd = (op == OP_W'(OPC_LOAD)) || (op == OP_W'(OPC_ADD)) ||
                      (op == OP_W'(OPC_SUB))  || (op == OP_W'(OPC_AND));

   always_comb begin
      nxt = state;
      unique case (state)
         S_FA:   nxt = S_FR;
         S_FR:   nxt = S_FM;
         S_FM:   nxt = S_FI;
         S_FI:   nxt = S_FP;
         S_FP:   nxt = S_DEC;
         S_DEC: begin
            if (op == OP_W'(OPC_HALT))       nxt = S_HLT;
            else if (op == OP_W'(OPC_STORE)) nxt = S_XA;
            else if (is_mem_rd)              nxt = S_XA;
            else if ((op == OP_W'(OPC_JUMP)) || (op == OP_W'(OPC_JZ))) nxt = S_BR;
            else                             nxt = S_FA;
         end
         S_XA:   nxt = (op == OP_W'(OPC_STORE)) ? S_SD : S_XR;
         S_XR:   nxt = S_XM;
         S_XM:   nxt = S_XACC;
         S_XACC: nxt = S_FA;
         S_SD:   nxt = S_SW;
         S_SW:   nxt = S_FA;
         S_BR:   nxt = S_FA;
         S_HLT:  nxt = S_HLT;
         default: nxt = S_FA;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_FA;
      else        state <= nxt;
   end

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_HLT |=> state == S_HLT);

   assert_exec_refetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SW || state == S_BR || state == S_XACC) |=> state == S_FA);

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 12,
   parameter int OP_W        = 4,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic [3:0]        dbg_state,
   output logic [ADDR_W-1:0] dbg_pc,
   output logic [ADDR_W-1:0] dbg_mar,
   output logic [DATA_W-1:0] dbg_mdr,
   output logic [DATA_W-1:0] dbg_ir,
   output logic [DATA_W-1:0] dbg_acc
);

   localparam int OP_LSB = DATA_W - OP_W;
   localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

   generate
      if (OP_W + ADDR_W != DATA_W) begin : g_bad_split
         $error("opcode and address fields must fill the data word");
      end
      if (OP_W < 3) begin : g_bad_op
         $error("opcode field too narrow for eight instructions");
      end
   endgenerate

   cpu_state_e        state;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
   logic [OP_W-1:0]   ir_op;
   logic [ADDR_W-1:0] ir_addr;
   logic [DATA_W-1:0] alu_y;
   logic              acc_zero, take_branch;

   assign ir_op       = ir_q[DATA_W-1:OP_LSB];
   assign ir_addr     = ir_q[ADDR_W-1:0];
   assign acc_zero    = (acc_q == '0);
   assign take_branch = (ir_op == OP_W'(OPC_JUMP)) ||
                        ((ir_op == OP_W'(OPC_JZ)) && acc_zero);

   acc_cpu_seq #(.OP_W(OP_W)) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ir_op),
      .state (state)
   );

   acc_cpu_alu #(.DATA_W(DATA_W), .OP_W(OP_W), .SUB_VIA_ADD(SUB_VIA_ADD)) alu_i (
      .op     (ir_op),
      .acc_in (acc_q),
      .opnd   (mdr_q),
      .result (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         ir_q  <= '0;
         acc_q <= '0;
      end else begin
         unique case (state)
            S_FA:   mar_q <= pc_q;
            S_FM:   mdr_q <= mem_rdata;
            S_FI:   ir_q  <= mdr_q;
            S_FP:   pc_q  <= pc_q + PC_STEP;
            S_XA:   mar_q <= ir_addr;
            S_XM:   mdr_q <= mem_rdata;
            S_XACC: acc_q <= alu_y;
            S_SD:   mdr_q <= acc_q;
            S_BR:   if (take_branch) pc_q <= ir_addr;
            default: ;
         endcase
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign mem_we    = (state == S_SW);
   assign halted    = (state == S_HLT);
   assign dbg_state = state;
   assign dbg_pc    = pc_q;
   assign dbg_mar   = mar_q;
   assign dbg_mdr   = mdr_q;
   assign dbg_ir    = ir_q;
   assign dbg_acc   = acc_q;

   assert_ir_from_mdr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_FI |=> ir_q == $past(mdr_q));

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_FP |=> pc_q == $past(pc_q) + PC_STEP);

   assert_dec_no_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_DEC |-> !mem_we ##1 ($stable(mar_q) && $stable(mdr_q)));

   assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   assert_store_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata == acc_q && mem_addr == ir_addr);

   assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc_q) && $stable(acc_q) && $stable(ir_q) && !mem_we);

endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata = '0;
   logic        halted;
   logic [3:0]  dbg_state;
   logic [11:0] dbg_pc, dbg_mar;
   logic [15:0] dbg_mdr, dbg_ir, dbg_acc;

   logic [15:0] mem    [0:4095];
   logic [15:0] refmem [0:4095];

   int checks = 0;
   int fails  = 0;
   int wr_cnt = 0;
   int wr_b2b = 0;
   int wd     = 0;
   logic prev_we = 1'b0;

   always #10 clk = ~clk;

   acc_cpu_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata), .halted(halted), .dbg_state(dbg_state),
      .dbg_pc(dbg_pc), .dbg_mar(dbg_mar), .dbg_mdr(dbg_mdr),
      .dbg_ir(dbg_ir), .dbg_acc(dbg_acc)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   always @(negedge clk) begin
      if (rst_n && mem_we) wr_cnt++;
      if (rst_n && mem_we && prev_we) wr_b2b++;
      prev_we = mem_we;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         fails++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", wd);
         $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ins(int op, int a);
      return {op[3:0], a[11:0]};
   endfunction

   // bench interpreter: final acc, pc, halt word, cycles, writes
   task automatic ref_run(output logic [15:0] racc, output logic [11:0] rpc,
                          output logic [15:0] rir, output int rcyc, output int rwr);
      logic [15:0] w;
      logic [11:0] a;
      bit done = 0;
      racc = '0; rpc = '0; rir = '0; rcyc = 0; rwr = 0;
      for (int k = 0; k < 4096; k++) refmem[k] = mem[k];
      for (int s = 0; s < 2000 && !done; s++) begin
         w = refmem[rpc]; a = w[11:0]; rir = w;
         rpc = rpc + 12'd1;
         rcyc += 6;
         case (w[15:12])
            4'd0: done = 1;
            4'd1: begin racc = refmem[a]; rcyc += 4; end
            4'd2: begin refmem[a] = racc; rcyc += 3; rwr++; end
            4'd3: begin racc = racc + refmem[a]; rcyc += 4; end
            4'd4: begin racc = racc - refmem[a]; rcyc += 4; end
            4'd5: begin racc = racc & refmem[a]; rcyc += 4; end
            4'd6: begin rpc = a; rcyc += 1; end
            4'd7: begin if (racc == 16'd0) rpc = a; rcyc += 1; end
            default: ;
         endcase
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_cnt = 0; wr_b2b = 0;
      rst_n = 1'b1;
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic finish_and_compare(string tag, int used);
      logic [15:0] eacc, eir;
      logic [11:0] epc;
      int ecyc, ewr, cyc, bad;
      ref_run(eacc, epc, eir, ecyc, ewr);
      cyc = used;
      while (!halted && cyc < 3000) begin step(); cyc++; end
      chk({tag, " R9 halted"}, 32'(halted), 32'd1);
      chk({tag, " R8 cycle count"}, 32'(cyc), 32'(ecyc));
      chk({tag, " R4/R5 acc"}, 32'(dbg_acc), 32'(eacc));
      chk({tag, " R7 pc"}, 32'(dbg_pc), 32'(epc));
      chk({tag, " R1 ir"}, 32'(dbg_ir), 32'(eir));
      chk({tag, " R6 write count"}, 32'(wr_cnt), 32'(ewr));
      chk({tag, " R6 single-cycle we"}, 32'(wr_b2b), 32'd0);
      bad = 0;
      for (int k = 0; k < 256; k++) if (mem[k] !== refmem[k]) bad++;
      chk({tag, " R6 memory image mismatches"}, 32'(bad), 32'd0);
   endtask

   task automatic clear_mem();
      for (int k = 0; k < 4096; k++) mem[k] = 16'h0000;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      clear_mem();

      // ---- directed program ----
      mem[0]  = ins(1, 20);  mem[1]  = ins(3, 21);  mem[2]  = ins(2, 22);
      mem[3]  = ins(7, 6);   mem[4]  = ins(4, 22);  mem[5]  = ins(7, 7);
      mem[6]  = ins(2, 23);  mem[7]  = ins(1, 24);  mem[8]  = ins(5, 25);
      mem[9]  = ins(9, 0);   mem[10] = ins(6, 12);  mem[11] = ins(2, 23);
      mem[12] = ins(2, 26);  mem[13] = ins(0, 0);
      mem[20] = 16'd5; mem[21] = 16'd7; mem[23] = 16'hBEEF;
      mem[24] = 16'h0F0F; mem[25] = 16'h3C3C;
      do_reset();
      chk("R11 reset state", 32'(dbg_state), 32'd0);
      chk("R11 reset pc", 32'(dbg_pc), 32'd0);
      chk("R11 reset acc", 32'(dbg_acc), 32'd0);
      chk("R11 reset ir", 32'(dbg_ir), 32'd0);
      chk("R11 reset halted/we", {30'd0, halted, mem_we}, 32'd0);
      step(); chk("R1 FA->FR", 32'(dbg_state), 32'd1);
      chk("R1 MAR<=PC", 32'(dbg_mar), 32'd0);
      step(); chk("R1 FR->FM", 32'(dbg_state), 32'd2);
      step(); chk("R1 MDR<=mem", 32'(dbg_mdr), 32'h1014);
      chk("R1 IR not yet loaded", 32'(dbg_ir), 32'd0);
      step(); chk("R1 IR<=MDR", 32'(dbg_ir), 32'h1014);
      chk("R2 PC not yet incremented", 32'(dbg_pc), 32'd0);
      step(); chk("R2 PC incremented in fetch", 32'(dbg_pc), 32'd1);
      chk("R2 now in decode", 32'(dbg_state), 32'd5);
      step(); chk("R3 decode kept MAR", 32'(dbg_mar), 32'd0);
      chk("R3 decode kept MDR", 32'(dbg_mdr), 32'h1014);
      chk("R4 load goes to XA", 32'(dbg_state), 32'd6);
      finish_and_compare("directed", 6);
      chk("R6 store wrote acc", 32'(mem[22]), 32'd12);
      chk("R7 skipped store untouched", 32'(mem[23]), 32'hBEEF);
      chk("R5 and result stored", 32'(mem[26]), 32'h0C0C);
      chk("R10 nop kept acc", 32'(dbg_acc), 32'h0C0C);
      begin
         logic [11:0] p; logic [15:0] a, r;
         p = dbg_pc; a = dbg_acc; r = dbg_ir; wr_cnt = 0;
         repeat (20) step();
         chk("R9 frozen pc", 32'(dbg_pc), 32'(p));
         chk("R9 frozen acc/ir", {dbg_acc, dbg_ir}, {a, r});
         chk("R9 no write while halted", 32'(wr_cnt), 32'd0);
      end

      // ---- PC wrap ----
      clear_mem();
      mem[0] = ins(7, 4095); mem[4095] = ins(1, 2); mem[2] = 16'h0077;
      mem[1] = ins(0, 0);
      do_reset();
      finish_and_compare("wrap R12", 0);
      chk("R12 wrap final pc", 32'(dbg_pc), 32'd2);
      chk("R12 wrap acc", 32'(dbg_acc), 32'h0077);

      // ---- SUB underflow and non-taken zero branch ----
      clear_mem();
      mem[0] = ins(4, 30); mem[1] = ins(7, 0); mem[2] = ins(15, 0);
      mem[3] = ins(0, 0); mem[30] = 16'd3;
      do_reset();
      finish_and_compare("underflow", 0);
      chk("R5 sub wraps", 32'(dbg_acc), 32'hFFFD);

      // ---- constrained random programs ----
      for (int t = 0; t < 30; t++) begin
         clear_mem();
         for (int i = 0; i < 19; i++) begin
            int r, d;
            r = $urandom_range(0, 99);
            d = 100 + $urandom_range(0, 15);
            if (r < 20)      mem[i] = ins(1, d);
            else if (r < 35) mem[i] = ins(3, d);
            else if (r < 48) mem[i] = ins(4, d);
            else if (r < 58) mem[i] = ins(5, d);
            else if (r < 75) mem[i] = ins(2, d);
            else if (r < 83) mem[i] = ins(6, i + 1 + $urandom_range(0, 18 - i));
            else if (r < 93) mem[i] = ins(7, i + 1 + $urandom_range(0, 18 - i));
            else             mem[i] = ins(8 + $urandom_range(0, 7), d);
         end
         mem[19] = ins(0, 0);
         for (int k = 100; k < 116; k++)
            mem[k] = ($urandom_range(0, 3) == 0) ? 16'd0 : 16'($urandom());
         do_reset();
         finish_and_compare($sformatf("random%0d", t), 0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule